// File: doc/BRIEF.md
# SONET Payload Pointer Interpreter

This block reads the two pointer bytes of each STS-3c frame, each arriving with its own strobe, and keeps track of the offset of the first byte of the synchronous payload envelope. It runs once per frame and works on the pointer only. Another block counts the frame bytes and uses the offset to find that first byte in the byte stream.

Each pointer word is sorted into one of six classes: all ones, new-data, increment, decrement, plain valid, or invalid. The class drives two things. A register path holds the offset and raises single-cycle event pulses. An alarm path keeps the loss-of-pointer (LOP) and path alarm-indication-signal (AIS) levels, and each of these has its own entry and exit runs.

The pointer word is the first pointer byte (bits 15:8) followed by the second (bits 7:0). The frame is taken in on the cycle where the second byte's strobe is high. If the first byte's strobe is high in the same cycle, that byte is used; otherwise the last byte it captured is used. All outputs are registered and change on the clock edge that takes in the frame.

Top module: `ptr_interp`

## Requirements
- R1: The offset does not change on cycles without a frame, or on a frame whose valid pointer equals the current offset. The increment, decrement and new-data outputs are high for one cycle only, on the cycle after the frame is taken in.
- R2: When word bits 15:12 are 1001 (new-data) and bits 9:0 are in range, the offset is loaded with bits 9:0 and the new-data output pulses.
- R3: A word with flag bits 15:12 = 0110 and an in-range value that differs from the offset is loaded only on the third consecutive frame carrying that same value. After one or two such frames the offset is unchanged.
- R4: Outside an alarm, a word with flag 0110 increments the offset by one when at least 3 of word bits 9,7,5,3,1 differ from the offset and at most 2 of bits 8,6,4,2,0 do. The increment output pulses, and 782 wraps to 0.
- R5: Outside an alarm, a word with flag 0110 decrements the offset by one when at least 3 of bits 8,6,4,2,0 differ from the offset and at most 2 of bits 9,7,5,3,1 do. The decrement output pulses, and 0 wraps to 782.
- R6: LOP rises on an invalid word: a flag other than 1001 or 0110, or an out-of-range value that is not a justification. The offset is not changed.
- R7: LOP rises on the eighth consecutive new-data frame, and not on the seventh.
- R8: LOP falls on the third consecutive frame with flag 0110 and an in-range value. The offset then takes that frame's value.
- R9: AIS rises on the third consecutive frame whose pointer word is all ones, not earlier, and LOP falls at the same edge.
- R10: While AIS is high, LOP stays low, even for invalid words. AIS falls on the third consecutive frame with flag 0110 and an in-range value, and the offset takes that value.
- R11: After reset the offset is 0, LOP is high, AIS is low and all pulses are low.
- R12: The pointer value is word bits 9:0, and 0 to 782 is in range. Word bits 11:10 have no effect. A new-data word with a value above 782 sets LOP and leaves the offset unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| h1_i | input | 8 | First pointer byte |
| h1_vld_i | input | 1 | First pointer byte strobe |
| h2_i | input | 8 | Second pointer byte |
| h2_vld_i | input | 1 | Second pointer byte strobe; marks the frame |
| offset_o | output | 10 | Current payload offset |
| inc_o | output | 1 | Increment justification pulse |
| dec_o | output | 1 | Decrement justification pulse |
| ndf_o | output | 1 | New-data load pulse |
| lop_o | output | 1 | Loss-of-pointer alarm |
| ais_o | output | 1 | Path AIS alarm |

## Verification
The assertions assume two things about the inputs. The second byte's strobe is high at most once per frame, and the first byte arrives in the same cycle as the second or earlier. The offset-step and idle-hold properties rely on these. The stimulus always presents both bytes together in one strobed cycle and leaves idle cycles between frames. The random pointer words are built relative to the offset the bench model expects: repeated pointers, vote patterns with 3 to 5 inverted bits, runs of new values, new-data words, all-ones bursts and out-of-range values.

// File: rtl/ptr_interp_pkg.sv
package ptr_interp_pkg;
  localparam int PTR_W = 10;
  localparam logic [3:0] FLAG_NEW  = 4'b1001;
  localparam logic [3:0] FLAG_NORM = 4'b0110;
  // vote groups: I = word bits 9,7,5,3,1 ; D = word bits 8,6,4,2,0
  localparam logic [PTR_W-1:0] INC_MASK = 10'h2AA;
  localparam logic [PTR_W-1:0] DEC_MASK = 10'h155;

  typedef enum logic [2:0] {
    K_AIS, K_NDF, K_INC, K_DEC, K_GOOD, K_BAD
  } ptr_kind_e;

  function automatic logic [3:0] pop_cnt(input logic [PTR_W-1:0] v);
    logic [3:0] c;
    c = '0;
    for (int i = 0; i < PTR_W; i++) c = c + {3'b000, v[i]};
    return c;
  endfunction
endpackage

// File: rtl/ptr_classify.sv
module ptr_classify
  import ptr_interp_pkg::*;
#(
  parameter int OFS_MAX  = 782,
  parameter int VOTE_MIN = 3
) (
  input  logic [15:0]      ptr_i,
  input  logic [PTR_W-1:0] offset_i,
  input  logic             alarm_i,
  output ptr_kind_e        kind_o,
  output logic [PTR_W-1:0] value_o,
  output logic             in_range_o
);
  localparam logic [PTR_W-1:0] MAX_V  = PTR_W'(OFS_MAX);
  localparam logic [3:0]       VOTE_L = 4'(VOTE_MIN);

  logic [3:0]       flag;
  logic [PTR_W-1:0] inv;
  logic [3:0]       n_inc, n_dec;
  logic             norm_flag;
  logic             ss_unused;

  assign ss_unused  = ^ptr_i[11:10];
  assign flag       = ptr_i[15:12];
  assign value_o    = ptr_i[PTR_W-1:0];
  assign inv        = value_o ^ offset_i;
  assign n_inc      = pop_cnt(inv & INC_MASK);
  assign n_dec      = pop_cnt(inv & DEC_MASK);
  assign in_range_o = (value_o <= MAX_V);
  assign norm_flag  = (flag == FLAG_NORM);

  always_comb begin
    if (ptr_i == 16'hFFFF)
      kind_o = K_AIS;
    else if (flag == FLAG_NEW)
      kind_o = K_NDF;
    else if (norm_flag && !alarm_i && n_inc >= VOTE_L && n_dec < VOTE_L)
      kind_o = K_INC;
    else if (norm_flag && !alarm_i && n_dec >= VOTE_L && n_inc < VOTE_L)
      kind_o = K_DEC;
    else if (norm_flag && in_range_o)
      kind_o = K_GOOD;
    else
      kind_o = K_BAD;
  end
endmodule

// File: rtl/ptr_alarm.sv
module ptr_alarm
  import ptr_interp_pkg::*;
#(
  parameter int CONF_RUN = 3,
  parameter int NDF_RUN  = 8
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      frame_i,
  input  ptr_kind_e kind_i,
  input  logic      in_range_i,
  output logic      lop_o,
  output logic      ais_o,
  output logic      alarm_o,
  output logic      exit_o
);
  localparam int CW = $clog2(CONF_RUN + 1);
  localparam int NW = $clog2(NDF_RUN + 1);
  localparam logic [CW-1:0] CONF_LAST = CW'(CONF_RUN - 1);
  localparam logic [NW-1:0] NDF_LAST  = NW'(NDF_RUN - 1);

  logic          lop_q, ais_q;
  logic [CW-1:0] ais_cnt_q, good_cnt_q;
  logic [NW-1:0] ndf_cnt_q;

  assign alarm_o = lop_q | ais_q;
  assign exit_o  = frame_i && kind_i == K_GOOD && alarm_o && good_cnt_q == CONF_LAST;
  assign lop_o   = lop_q & ~ais_q;
  assign ais_o   = ais_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lop_q      <= 1'b1;
      ais_q      <= 1'b0;
      ais_cnt_q  <= '0;
      good_cnt_q <= '0;
      ndf_cnt_q  <= '0;
    end else if (frame_i) begin
      ais_cnt_q  <= (kind_i != K_AIS)  ? '0 :
                    (ais_cnt_q == CONF_LAST) ? ais_cnt_q : ais_cnt_q + 1'b1;
      good_cnt_q <= (kind_i != K_GOOD) ? '0 :
                    (good_cnt_q == CONF_LAST) ? good_cnt_q : good_cnt_q + 1'b1;
      ndf_cnt_q  <= (kind_i != K_NDF)  ? '0 :
                    (ndf_cnt_q == NDF_LAST) ? ndf_cnt_q : ndf_cnt_q + 1'b1;
      case (kind_i)
        K_AIS:  if (ais_cnt_q == CONF_LAST) begin
                  ais_q <= 1'b1;
                  lop_q <= 1'b0;
                end
        K_NDF:  if (!ais_q && (!in_range_i || ndf_cnt_q == NDF_LAST)) lop_q <= 1'b1;
        K_GOOD: if (exit_o) begin
                  lop_q <= 1'b0;
                  ais_q <= 1'b0;
                end
        K_BAD:  if (!ais_q) lop_q <= 1'b1;
        default: ;
      endcase
    end
  end

  p_lop_ais_excl_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(lop_q && ais_q));
  p_bad_sets_lop_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_i && kind_i == K_BAD && !ais_q |=> lop_o);
  p_exit_clears_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exit_o |=> !lop_o && !ais_o);
  p_ais_entry_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ais_q) |-> $past(frame_i) && $past(kind_i) == K_AIS);
endmodule

// File: rtl/ptr_offset.sv
module ptr_offset
  import ptr_interp_pkg::*;
#(
  parameter int OFS_MAX  = 782,
  parameter int CONF_RUN = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             frame_i,
  input  ptr_kind_e        kind_i,
  input  logic [PTR_W-1:0] value_i,
  input  logic             in_range_i,
  input  logic             alarm_i,
  input  logic             exit_i,
  output logic [PTR_W-1:0] offset_o,
  output logic             inc_o,
  output logic             dec_o,
  output logic             ndf_o
);
  localparam int CW = $clog2(CONF_RUN + 1);
  localparam logic [CW-1:0]    CONF_LAST = CW'(CONF_RUN - 1);
  localparam logic [PTR_W-1:0] MAX_V     = PTR_W'(OFS_MAX);

  logic [PTR_W-1:0] offset_q, cand_q, ofs_up, ofs_dn;
  logic [CW-1:0]    cand_cnt_q;
  logic             inc_q, dec_q, ndf_q;

  assign ofs_up   = (offset_q == MAX_V) ? '0 : offset_q + 1'b1;
  assign ofs_dn   = (offset_q == '0) ? MAX_V : offset_q - 1'b1;
  assign offset_o = offset_q;
  assign inc_o    = inc_q;
  assign dec_o    = dec_q;
  assign ndf_o    = ndf_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      offset_q   <= '0;
      cand_q     <= '0;
      cand_cnt_q <= '0;
      inc_q      <= 1'b0;
      dec_q      <= 1'b0;
      ndf_q      <= 1'b0;
    end else begin
      inc_q <= 1'b0;
      dec_q <= 1'b0;
      ndf_q <= 1'b0;
      if (frame_i) begin
        case (kind_i)
          K_NDF: begin
            cand_cnt_q <= '0;
            if (in_range_i) begin
              offset_q <= value_i;
              ndf_q    <= 1'b1;
            end
          end
          K_INC: begin
            cand_cnt_q <= '0;
            offset_q   <= ofs_up;
            inc_q      <= 1'b1;
          end
          K_DEC: begin
            cand_cnt_q <= '0;
            offset_q   <= ofs_dn;
            dec_q      <= 1'b1;
          end
          K_GOOD: begin
            if (exit_i) begin
              offset_q   <= value_i;
              cand_cnt_q <= '0;
            end else if (alarm_i || value_i == offset_q) begin
              cand_cnt_q <= '0;
            end else if (cand_cnt_q != '0 && value_i == cand_q) begin
              if (cand_cnt_q == CONF_LAST) begin
                offset_q   <= value_i;
                cand_cnt_q <= '0;
              end else begin
                cand_cnt_q <= cand_cnt_q + 1'b1;
              end
            end else begin
              cand_q     <= value_i;
              cand_cnt_q <= CW'(1);
            end
          end
          default: cand_cnt_q <= '0;
        endcase
      end
    end
  end

  p_hold_idle_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_i |=> $stable(offset_q));
  p_offset_range_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    offset_q <= MAX_V);
  p_pulse_excl_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({inc_q, dec_q, ndf_q}));
  p_inc_step_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inc_q |-> offset_q == (($past(offset_q) == MAX_V) ? '0 : $past(offset_q) + 1'b1));
  p_dec_step_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_q |-> offset_q == (($past(offset_q) == '0) ? MAX_V : $past(offset_q) - 1'b1));
endmodule

// File: rtl/ptr_interp.sv
module ptr_interp
  import ptr_interp_pkg::*;
#(
  parameter int OFS_MAX  = 782,
  parameter int VOTE_MIN = 3,
  parameter int CONF_RUN = 3,
  parameter int NDF_RUN  = 8
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [7:0] h1_i,
  input  logic       h1_vld_i,
  input  logic [7:0] h2_i,
  input  logic       h2_vld_i,
  output logic [9:0] offset_o,
  output logic       inc_o,
  output logic       dec_o,
  output logic       ndf_o,
  output logic       lop_o,
  output logic       ais_o
);
  logic [7:0]       h1_q, h1_cur;
  logic [15:0]      ptr_w;
  ptr_kind_e        kind;
  logic [PTR_W-1:0] value;
  logic             in_range, alarm, exit_w;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       h1_q <= '0;
    else if (h1_vld_i) h1_q <= h1_i;
  end

  assign h1_cur = h1_vld_i ? h1_i : h1_q;
  assign ptr_w  = {h1_cur, h2_i};

  ptr_classify #(.OFS_MAX(OFS_MAX), .VOTE_MIN(VOTE_MIN)) u_classify (
    .ptr_i      (ptr_w),
    .offset_i   (offset_o),
    .alarm_i    (alarm),
    .kind_o     (kind),
    .value_o    (value),
    .in_range_o (in_range)
  );

  ptr_alarm #(.CONF_RUN(CONF_RUN), .NDF_RUN(NDF_RUN)) u_alarm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .frame_i    (h2_vld_i),
    .kind_i     (kind),
    .in_range_i (in_range),
    .lop_o      (lop_o),
    .ais_o      (ais_o),
    .alarm_o    (alarm),
    .exit_o     (exit_w)
  );

  ptr_offset #(.OFS_MAX(OFS_MAX), .CONF_RUN(CONF_RUN)) u_offset (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .frame_i    (h2_vld_i),
    .kind_i     (kind),
    .value_i    (value),
    .in_range_i (in_range),
    .alarm_i    (alarm),
    .exit_i     (exit_w),
    .offset_o   (offset_o),
    .inc_o      (inc_o),
    .dec_o      (dec_o),
    .ndf_o      (ndf_o)
  );

  p_lop_masked_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ais_o |-> !lop_o);
endmodule

// File: tb/ptr_interp_tb.sv
`timescale 1ns/1ps
module ptr_interp_tb;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] h1_i = '0, h2_i = '0;
  logic       h1_vld_i = 1'b0, h2_vld_i = 1'b0;
  logic [9:0] offset_o;
  logic       inc_o, dec_o, ndf_o, lop_o, ais_o;

  int n_chk = 0, n_err = 0;
  bit done = 1'b0;

  // bench model state
  int m_ofs, m_lop, m_ais, m_ais_cnt, m_ndf_cnt, m_good, m_cand, m_cand_cnt;
  int m_inc, m_dec, m_ndf;

  always #2.5 clk = ~clk;

  ptr_interp u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .h1_i(h1_i), .h1_vld_i(h1_vld_i),
    .h2_i(h2_i), .h2_vld_i(h2_vld_i), .offset_o(offset_o), .inc_o(inc_o),
    .dec_o(dec_o), .ndf_o(ndf_o), .lop_o(lop_o), .ais_o(ais_o)
  );

  function automatic int ones(input logic [9:0] v);
    int c = 0;
    for (int i = 0; i < 10; i++) c += int'(v[i]);
    return c;
  endfunction

  function automatic logic [15:0] mk(input logic [3:0] f, input int v);
    return {f, 2'b00, 10'(v)};
  endfunction

  function automatic logic [9:0] spread(input logic [4:0] s, input bit odd);
    logic [9:0] r = '0;
    for (int k = 0; k < 5; k++) r[2*k + (odd ? 1 : 0)] = s[k];
    return r;
  endfunction

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic model_reset();
    m_ofs = 0; m_lop = 1; m_ais = 0; m_ais_cnt = 0; m_ndf_cnt = 0;
    m_good = 0; m_cand = 0; m_cand_cnt = 0; m_inc = 0; m_dec = 0; m_ndf = 0;
  endtask

  task automatic model_frame(input logic [15:0] p, output string tag);
    logic [3:0] f = p[15:12];
    int v = int'(p[9:0]);
    logic [9:0] x = p[9:0] ^ 10'(m_ofs);
    int ni = ones(x & 10'h2AA);
    int nd = ones(x & 10'h155);
    int alarm = m_lop | m_ais;
    m_inc = 0; m_dec = 0; m_ndf = 0;
    if (p == 16'hFFFF) begin
      tag = "R9";
      m_ndf_cnt = 0; m_good = 0; m_cand_cnt = 0;
      m_ais_cnt++;
      if (m_ais_cnt >= 3) begin m_ais = 1; m_lop = 0; end
    end else if (f == 4'b1001) begin
      tag = "R2";
      m_ais_cnt = 0; m_good = 0; m_cand_cnt = 0;
      m_ndf_cnt++;
      if (v <= 782) begin m_ofs = v; m_ndf = 1; end
      else if (!m_ais) m_lop = 1;
      if (m_ndf_cnt >= 8 && !m_ais) m_lop = 1;
    end else if (f == 4'b0110 && !alarm && ni >= 3 && nd < 3) begin
      tag = "R4";
      m_ais_cnt = 0; m_ndf_cnt = 0; m_good = 0; m_cand_cnt = 0;
      m_ofs = (m_ofs == 782) ? 0 : m_ofs + 1; m_inc = 1;
    end else if (f == 4'b0110 && !alarm && nd >= 3 && ni < 3) begin
      tag = "R5";
      m_ais_cnt = 0; m_ndf_cnt = 0; m_good = 0; m_cand_cnt = 0;
      m_ofs = (m_ofs == 0) ? 782 : m_ofs - 1; m_dec = 1;
    end else if (f == 4'b0110 && v <= 782) begin
      m_ais_cnt = 0; m_ndf_cnt = 0;
      if (m_good < 3) m_good++;
      if (alarm) begin
        tag = "R8";
        m_cand_cnt = 0;
        if (m_good >= 3) begin m_lop = 0; m_ais = 0; m_ofs = v; end
      end else if (v == m_ofs) begin
        tag = "R1"; m_cand_cnt = 0;
      end else if (m_cand_cnt > 0 && v == m_cand) begin
        tag = "R3"; m_cand_cnt++;
        if (m_cand_cnt >= 3) begin m_ofs = v; m_cand_cnt = 0; end
      end else begin
        tag = "R3"; m_cand = v; m_cand_cnt = 1;
      end
    end else begin
      tag = "R6";
      m_ais_cnt = 0; m_ndf_cnt = 0; m_good = 0; m_cand_cnt = 0;
      if (!m_ais) m_lop = 1;
    end
  endtask

  task automatic compare_all(input string tag);
    chk(tag, "offset", int'(offset_o), m_ofs);
    chk(tag, "inc", int'(inc_o), m_inc);
    chk(tag, "dec", int'(dec_o), m_dec);
    chk(tag, "ndf", int'(ndf_o), m_ndf);
    chk(tag, "lop", int'(lop_o), (m_lop != 0 && m_ais == 0) ? 1 : 0);
    chk(tag, "ais", int'(ais_o), m_ais);
  endtask

  // one frame: drive, take in at posedge, check after it, then check pulse end
  task automatic send(input logic [15:0] p);
    string tag;
    @(negedge clk);
    h1_i = p[15:8]; h2_i = p[7:0]; h1_vld_i = 1'b1; h2_vld_i = 1'b1;
    @(negedge clk);
    h1_vld_i = 1'b0; h2_vld_i = 1'b0;
    h1_i = 8'($urandom); h2_i = 8'($urandom);
    model_frame(p, tag);
    compare_all(tag);
    @(negedge clk);
    chk("R1", "pulse end", int'({inc_o, dec_o, ndf_o}), 0);
    chk("R1", "idle hold", int'(offset_o), m_ofs);
  endtask

  task automatic rand_frame();
    int r = $urandom_range(0, 99);
    logic [1:0] ss = 2'($urandom);
    logic [4:0] a, b;
    if (r < 35) begin
      send({4'b0110, ss, 10'(m_ofs)});
    end else if (r < 55) begin
      do a = 5'($urandom); while (ones({5'b0, a}) < 3);
      do b = 5'($urandom); while (ones({5'b0, b}) > 2);
      if (r < 45) send({4'b0110, ss, 10'(m_ofs) ^ spread(a, 1'b1) ^ spread(b, 1'b0)});
      else        send({4'b0110, ss, 10'(m_ofs) ^ spread(a, 1'b0) ^ spread(b, 1'b1)});
    end else if (r < 63) begin
      send({4'b1001, ss, 10'($urandom_range(0, (r == 62) ? 1023 : 782))});
    end else if (r < 78) begin
      int nv = $urandom_range(0, 782);
      int n = $urandom_range(1, 3);
      for (int i = 0; i < n; i++) send(mk(4'b0110, nv));
    end else if (r < 85) begin
      logic [3:0] f;
      do f = 4'($urandom); while (f == 4'b0110 || f == 4'b1001 || f == 4'b1111);
      send({f, ss, 10'($urandom)});
    end else if (r < 93) begin
      int n = $urandom_range(1, 4);
      for (int i = 0; i < n; i++) send(16'hFFFF);
    end else begin
      send({4'b0110, ss, 10'($urandom_range(783, 1023))});
    end
  endtask

  initial begin
    void'($urandom(32'd715));
    model_reset();
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11", "offset", int'(offset_o), 0);
    chk("R11", "lop", int'(lop_o), 1);
    chk("R11", "ais", int'(ais_o), 0);
    chk("R11", "pulses", int'({inc_o, dec_o, ndf_o}), 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);

    // R8 exit from reset LOP
    send(mk(4'b0110, 100)); send(mk(4'b0110, 100));
    chk("R8", "lop after two", int'(lop_o), 1);
    send(mk(4'b0110, 100));
    chk("R8", "lop after three", int'(lop_o), 0);
    chk("R8", "offset loaded", int'(offset_o), 100);

    // R1 hold on equal pointer
    send(mk(4'b0110, 100));
    chk("R1", "offset held", int'(offset_o), 100);

    // R3 new value needs three
    send(mk(4'b0110, 103)); send(mk(4'b0110, 103));
    chk("R3", "offset after two", int'(offset_o), 100);
    send(mk(4'b0110, 103));
    chk("R3", "offset after three", int'(offset_o), 103);

    // R4 / R5 justification
    send({4'b0110, 2'b00, 10'd103 ^ 10'h2AA});
    chk("R4", "inc step", int'(offset_o), 104);
    send({4'b0110, 2'b00, 10'd104 ^ 10'h155});
    chk("R5", "dec step", int'(offset_o), 103);

    // R2 new-data, then wrap both ways
    send(mk(4'b1001, 782));
    chk("R2", "ndf load", int'(offset_o), 782);
    send({4'b0110, 2'b00, 10'd782 ^ 10'h2AA});
    chk("R4", "inc wrap", int'(offset_o), 0);
    send({4'b0110, 2'b00, 10'd0 ^ 10'h155});
    chk("R5", "dec wrap", int'(offset_o), 782);

    // R12 SS bits ignored
    send({4'b0110, 2'b11, 10'd782});
    chk("R12", "ss ignored", int'(offset_o), 782);
    chk("R12", "ss no lop", int'(lop_o), 0);

    // R6 invalid flag
    send(mk(4'b0000, 5));
    chk("R6", "lop on invalid", int'(lop_o), 1);
    chk("R6", "offset kept", int'(offset_o), 782);
    for (int i = 0; i < 3; i++) send(mk(4'b0110, 50));
    chk("R8", "recover", int'(lop_o), 0);

    // R12 out-of-range new-data
    send(mk(4'b1001, 783));
    chk("R12", "range lop", int'(lop_o), 1);
    chk("R12", "range offset", int'(offset_o), 50);
    for (int i = 0; i < 3; i++) send(mk(4'b0110, 60));

    // R7 eight new-data frames
    for (int i = 0; i < 7; i++) send(mk(4'b1001, 60));
    chk("R7", "lop after seven", int'(lop_o), 0);
    send(mk(4'b1001, 60));
    chk("R7", "lop after eight", int'(lop_o), 1);
    for (int i = 0; i < 3; i++) send(mk(4'b0110, 60));

    // R9 / R10 AIS
    send(16'hFFFF); send(16'hFFFF);
    chk("R9", "ais after two", int'(ais_o), 0);
    send(16'hFFFF);
    chk("R9", "ais after three", int'(ais_o), 1);
    send(mk(4'b0000, 0));
    chk("R10", "lop masked", int'(lop_o), 0);
    send(mk(4'b0110, 70)); send(mk(4'b0110, 70));
    chk("R10", "ais held", int'(ais_o), 1);
    send(mk(4'b0110, 70));
    chk("R10", "ais cleared", int'(ais_o), 0);
    chk("R10", "offset on exit", int'(offset_o), 70);

    // R10 AIS entered from LOP
    send(mk(4'b0000, 1));
    for (int i = 0; i < 3; i++) send(16'hFFFF);
    chk("R10", "lop low in ais", int'(lop_o), 0);

    for (int i = 0; i < 3000; i++) rand_frame();

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
      $finish;
    end
  end
endmodule